// File: doc/BRIEF.md
# Paired 64-bit Access Sequencer

This block sits between a 32-bit debug register port and a system bus that can carry 64-bit transfers. When the debug side selects the wide access size, two 32-bit debug accesses make one 64-bit bus transfer. The pair goes either to the single data register twice, or to an even/odd pair of banked data registers, even member first. The sequencer checks that each pair follows this order. It splits the read word or builds the write word, and it places each bus error on the debug access that the bus transfer belongs to.

A read pair starts the bus read on its first debug read. That read returns the low half, and the partner read returns the buffered high half without touching the bus. A write pair buffers the low half on its first debug write and issues the bus write when the partner write supplies the high half. An access that breaks a pair completes at once with an error, with no bus activity, and the sequencer drops the partial word. When the wide size is not selected, each debug access maps to one 32-bit bus access.

Top module: `wide_pair_seq`

## Requirements
- R1: During reset and after it, `dbg_ready`, `dbg_err` and `bus_req` are low, and the sequencer starts with no pair open.
- R2: A debug request is held until `dbg_ready` is high for one cycle. `dbg_err` and `dbg_rdata` are valid only in that cycle. A request is never taken in the cycle that `dbg_ready` is high.
- R3: With `dbg_wide`=0 and no pair open, each debug access makes one narrow bus access. The write data goes in the low lane with the upper lane zero. Read data is `bus_rdata` bits [DW-1:0], read data on a write is zero, and `bus_err` is returned as `dbg_err`.
- R4: With `dbg_wide`=1 and no pair open, a read of the data register (`dbg_banked`=0) or of an even banked register starts one 64-bit bus read. When the bus completes, the debug read returns the low half.
- R5: The partner read of an open read pair returns the buffered high half one cycle after it is accepted and makes no bus access.
- R6: With `dbg_wide`=1 and no pair open, a write of the data register or of an even banked register makes no bus access. It completes one cycle after acceptance without error and opens a write pair.
- R7: The partner write of an open write pair issues one 64-bit bus write. Its data is {partner data, first data}, and the debug write completes when the bus does.
- R8: A bus error on a 64-bit read is reported on the first read of the pair, with zero data. The partner read then completes without error and returns zero.
- R9: A bus error on a 64-bit write is reported on the partner write. The first write of a pair never reports an error.
- R10: A banked pair is register 2k followed by register 2k+1 in the same direction. Accessing an odd banked register with `dbg_wide`=1 and no pair open is an error.
- R11: While a pair is open, any other access is a violation: the opposite direction, the other register kind, or a banked register that is not the partner. A violation completes one cycle after acceptance with `dbg_err`=1 and zero data. It makes no bus access, closes the pair and discards the partial word.
- R12: A 64-bit bus address has its low three bits zero. For the data register it is `base_addr` with bits [2:0] cleared. For banked pair 2k it is {`base_addr`[AW-1:BIDX_W+2], 2k, 2'b00}. A narrow banked access to register n uses {`base_addr`[AW-1:BIDX_W+2], n, 2'b00}. A narrow access to the data register uses `base_addr` with bits [1:0] cleared.
- R13: While a pair is open, `dbg_wide` is ignored, and the partner access completes the pair even with `dbg_wide`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Debug access request, held until dbg_ready |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_banked | input | 1 | 0 = single data register, 1 = banked register |
| dbg_bank | input | $clog2(NBANK) | Banked register number |
| dbg_wide | input | 1 | 1 = 64-bit access size |
| dbg_wdata | input | DW | Debug write data |
| base_addr | input | AW | Transfer base address |
| dbg_ready | output | 1 | One-cycle completion strobe |
| dbg_rdata | output | DW | Read data, valid with dbg_ready |
| dbg_err | output | 1 | Slave error, valid with dbg_ready |
| bus_req | output | 1 | Bus request, held until bus_done |
| bus_write | output | 1 | Bus transfer direction |
| bus_wide | output | 1 | 1 = 64-bit bus transfer |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 2*DW | Bus write data |
| bus_done | input | 1 | Bus transfer complete |
| bus_err | input | 1 | Bus error, valid with bus_done |
| bus_rdata | input | 2*DW | Bus read data, valid with bus_done |

## Verification
The bench looks for a pair that lets a broken sequence through. It reads during an open write pair, accesses a non-partner bank during an open read pair, and starts a pair on an odd bank. A sequencer that kept the pair open after the error would fold stale low data into the next bus write, or answer the next read from its buffer without a bus read, and the scoreboard would see a missing bus transfer or the wrong wdata. Error placement is covered in both directions: an error report moved to the other half of a pair shows up as a wrong `dbg_err` on a specific access. Completion latency separates the buffered halves from the halves that go to the bus, and a partner with `dbg_wide`=0 shows whether a design drops the pair when the size input changes.

// File: rtl/wps_pkg.sv
`timescale 1ns/1ps
package wps_pkg;

  // Pair sequencing state
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD2  = 2'd1,
    SEQ_WR2  = 2'd2
  } seq_e;

  // What an accepted debug access does
  typedef enum logic [2:0] {
    ACT_NARROW    = 3'd0,
    ACT_RD_FIRST  = 3'd1,
    ACT_RD_SECOND = 3'd2,
    ACT_WR_FIRST  = 3'd3,
    ACT_WR_SECOND = 3'd4,
    ACT_BREAK     = 3'd5
  } act_e;

  // Bus operation in flight
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_NARROW = 2'd1,
    OP_RD64   = 2'd2,
    OP_WR64   = 2'd3
  } op_e;

endpackage

// File: rtl/wps_classify.sv
`timescale 1ns/1ps
module wps_classify
  import wps_pkg::*;
#(
  parameter int BIDX_W = 2
) (
  input  seq_e              seq,
  input  logic              pair_banked,
  input  logic [BIDX_W-1:0] pair_idx,
  input  logic              write,
  input  logic              banked,
  input  logic [BIDX_W-1:0] idx,
  input  logic              wide,
  output act_e              act
);

  localparam logic [BIDX_W-1:0] ODD_BIT = BIDX_W'(1);

  logic partner;

  // The second access must hit the same register kind; for banks, the odd mate
  always_comb begin
    partner = (banked == pair_banked) && (!banked || (idx == (pair_idx | ODD_BIT)));
  end

  always_comb begin
    act = ACT_BREAK;
    unique case (seq)
      SEQ_IDLE: begin
        if (!wide)                act = ACT_NARROW;
        else if (banked && idx[0]) act = ACT_BREAK;
        else if (write)           act = ACT_WR_FIRST;
        else                      act = ACT_RD_FIRST;
      end
      SEQ_RD2: act = (!write && partner) ? ACT_RD_SECOND : ACT_BREAK;
      SEQ_WR2: act = ( write && partner) ? ACT_WR_SECOND : ACT_BREAK;
      default: act = ACT_BREAK;
    endcase
  end

endmodule

// File: rtl/wps_addr.sv
`timescale 1ns/1ps
module wps_addr #(
  parameter int AW      = 32,
  parameter int BIDX_W  = 2,
  parameter int BYTE_SH = 2
) (
  input  logic [AW-1:0]     base,
  input  logic              banked,
  input  logic [BIDX_W-1:0] idx,
  input  logic              wide,
  output logic [AW-1:0]     addr
);

  localparam logic [AW-1:0] WORD_MASK = {{(AW-BYTE_SH){1'b1}}, {BYTE_SH{1'b0}}};
  localparam logic [AW-1:0] DBL_MASK  = {{(AW-BYTE_SH-1){1'b1}}, {(BYTE_SH+1){1'b0}}};
  localparam logic [BIDX_W-1:0] EVEN_MASK = ~BIDX_W'(1);

  logic [BIDX_W-1:0] idx_eff;
  logic [AW-1:0]     bank_addr;

  always_comb begin
    idx_eff   = wide ? (idx & EVEN_MASK) : idx;
    bank_addr = {base[AW-1:BIDX_W+BYTE_SH], idx_eff, {BYTE_SH{1'b0}}};
    if (banked) addr = bank_addr;
    else        addr = base & (wide ? DBL_MASK : WORD_MASK);
  end

endmodule

// File: rtl/wps_bus_port.sv
`timescale 1ns/1ps
module wps_bus_port #(
  parameter int AW = 32,
  parameter int BW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          l_write,
  input  logic          l_wide,
  input  logic [AW-1:0] l_addr,
  input  logic [BW-1:0] l_wdata,
  input  logic          bus_done,
  output logic          bus_req,
  output logic          bus_write,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [BW-1:0] bus_wdata,
  output logic          done
);

  logic          req_q, req_d;
  logic          wr_q, wide_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] wdata_q;

  always_comb begin
    done  = req_q & bus_done;
    req_d = req_q;
    if (launch)    req_d = 1'b1;
    else if (done) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  // Command fields load only on launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      wr_q    <= l_write;
      wide_q  <= l_wide;
      addr_q  <= l_addr;
      wdata_q <= l_wdata;
    end
  end

  assign bus_req   = req_q;
  assign bus_write = wr_q;
  assign bus_wide  = wide_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  // R3: an open bus request keeps its command stable until it completes
  a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !bus_done) |=> (req_q && $stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));

  // R2: no new launch while a bus transfer is open
  a_r2_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !launch);

endmodule

// File: rtl/wide_pair_seq.sv
`timescale 1ns/1ps
module wide_pair_seq
  import wps_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NBANK = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dbg_req,
  input  logic                     dbg_write,
  input  logic                     dbg_banked,
  input  logic [$clog2(NBANK)-1:0] dbg_bank,
  input  logic                     dbg_wide,
  input  logic [DW-1:0]            dbg_wdata,
  input  logic [AW-1:0]            base_addr,
  output logic                     dbg_ready,
  output logic [DW-1:0]            dbg_rdata,
  output logic                     dbg_err,
  output logic                     bus_req,
  output logic                     bus_write,
  output logic                     bus_wide,
  output logic [AW-1:0]            bus_addr,
  output logic [2*DW-1:0]          bus_wdata,
  input  logic                     bus_done,
  input  logic                     bus_err,
  input  logic [2*DW-1:0]          bus_rdata
);

  localparam int BW      = 2 * DW;
  localparam int BIDX_W  = $clog2(NBANK);
  localparam int BYTE_SH = $clog2(DW / 8);
  localparam logic [BIDX_W-1:0] EVEN_MASK = ~BIDX_W'(1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // State
  seq_e              seq_q, seq_d;
  op_e               op_q, op_d;
  logic              pb_q, pb_d;
  logic [BIDX_W-1:0] pi_q, pi_d;
  logic [DW-1:0]     lo_q, lo_d;
  logic [DW-1:0]     hi_q, hi_d;
  logic              ready_q, ready_d;
  logic              err_q, err_d;
  logic [DW-1:0]     rdata_q, rdata_d;

  // Internal wiring
  act_e          act;
  logic          accept;
  logic          launch;
  logic          l_wide;
  logic [BW-1:0] l_wdata;
  logic [AW-1:0] l_addr;
  logic          done;

  wps_classify #(.BIDX_W(BIDX_W)) u_classify (
    .seq        (seq_q),
    .pair_banked(pb_q),
    .pair_idx   (pi_q),
    .write      (dbg_write),
    .banked     (dbg_banked),
    .idx        (dbg_bank),
    .wide       (dbg_wide),
    .act        (act)
  );

  wps_addr #(.AW(AW), .BIDX_W(BIDX_W), .BYTE_SH(BYTE_SH)) u_addr (
    .base  (base_addr),
    .banked(dbg_banked),
    .idx   (dbg_bank),
    .wide  (l_wide),
    .addr  (l_addr)
  );

  wps_bus_port #(.AW(AW), .BW(BW)) u_bus (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .launch   (launch),
    .l_write  (dbg_write),
    .l_wide   (l_wide),
    .l_addr   (l_addr),
    .l_wdata  (l_wdata),
    .bus_done (bus_done),
    .bus_req  (bus_req),
    .bus_write(bus_write),
    .bus_wide (bus_wide),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .done     (done)
  );

  assign accept = dbg_req && !bus_req && !ready_q;

  // Next-state logic
  always_comb begin
    seq_d   = seq_q;
    op_d    = op_q;
    pb_d    = pb_q;
    pi_d    = pi_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    ready_d = 1'b0;
    err_d   = 1'b0;
    rdata_d = '0;
    launch  = 1'b0;
    l_wide  = 1'b0;
    l_wdata = {{DW{1'b0}}, dbg_wdata};

    if (done) begin
      ready_d = 1'b1;
      err_d   = bus_err;
      op_d    = OP_NONE;
      unique case (op_q)
        OP_NARROW: rdata_d = bus_write ? '0 : bus_rdata[DW-1:0];
        OP_RD64: begin
          rdata_d = bus_err ? '0 : bus_rdata[DW-1:0];
          hi_d    = bus_err ? '0 : bus_rdata[BW-1:DW];
          seq_d   = SEQ_RD2;
        end
        default: rdata_d = '0;
      endcase
    end else if (accept) begin
      unique case (act)
        ACT_NARROW: begin
          launch = 1'b1;
          op_d   = OP_NARROW;
        end
        ACT_RD_FIRST: begin
          launch = 1'b1;
          l_wide = 1'b1;
          op_d   = OP_RD64;
          pb_d   = dbg_banked;
          pi_d   = dbg_bank & EVEN_MASK;
        end
        ACT_WR_FIRST: begin
          ready_d = 1'b1;
          lo_d    = dbg_wdata;
          seq_d   = SEQ_WR2;
          pb_d    = dbg_banked;
          pi_d    = dbg_bank & EVEN_MASK;
        end
        ACT_RD_SECOND: begin
          ready_d = 1'b1;
          rdata_d = hi_q;
          hi_d    = '0;
          seq_d   = SEQ_IDLE;
        end
        ACT_WR_SECOND: begin
          launch  = 1'b1;
          l_wide  = 1'b1;
          l_wdata = {dbg_wdata, lo_q};
          lo_d    = '0;
          seq_d   = SEQ_IDLE;
          op_d    = OP_WR64;
        end
        default: begin
          ready_d = 1'b1;
          err_d   = 1'b1;
          seq_d   = SEQ_IDLE;
          lo_d    = '0;
          hi_d    = '0;
        end
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seq_q   <= SEQ_IDLE;
      op_q    <= OP_NONE;
      pb_q    <= 1'b0;
      pi_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      seq_q   <= seq_d;
      op_q    <= op_d;
      pb_q    <= pb_d;
      pi_q    <= pi_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      ready_q <= ready_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign dbg_ready = ready_q;
  assign dbg_err   = err_q;
  assign dbg_rdata = rdata_q;

  // R2: completion is a single-cycle strobe
  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_ready |=> !dbg_ready);

  // R2: an error is only signalled together with completion
  a_r2_err_with_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_err |-> dbg_ready);

  // R5: the partner read is served from the buffer, so the bus stays idle
  a_r5_rd2_bus_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_q == SEQ_RD2) |-> !bus_req);

  // R6: an open write pair has not touched the bus
  a_r6_wr2_bus_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_q == SEQ_WR2) |-> !bus_req);

  // R4: a first wide read starts a 64-bit bus read
  a_r4_read_launch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && act == ACT_RD_FIRST) |=> (bus_req && bus_wide && !bus_write));

  // R7: the partner write issues a 64-bit write whose upper half is its data
  a_r7_write_launch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && act == ACT_WR_SECOND) |=>
      (bus_req && bus_wide && bus_write && bus_wdata[BW-1:DW] == $past(dbg_wdata)));

  // R11: a sequence violation errors out without a bus transfer
  a_r11_break_no_bus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && act == ACT_BREAK) |=> (!bus_req && dbg_err && dbg_ready));

  // R12: every 64-bit bus address is doubleword aligned
  a_r12_wide_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_wide) |-> (bus_addr[BYTE_SH:0] == '0));

endmodule

// File: tb/wide_pair_seq_tb.sv
`timescale 1ns/1ps
module wide_pair_seq_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NBANK = 4;
  localparam logic [AW-1:0] BASE = 32'h0000_4A67;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dbg_req, dbg_write, dbg_banked, dbg_wide;
  logic [1:0]    dbg_bank;
  logic [DW-1:0] dbg_wdata;
  logic [AW-1:0] base_addr;
  logic          dbg_ready, dbg_err;
  logic [DW-1:0] dbg_rdata;
  logic          bus_req, bus_write, bus_wide;
  logic [AW-1:0] bus_addr;
  logic [2*DW-1:0] bus_wdata;
  logic          bus_done, bus_err;
  logic [2*DW-1:0] bus_rdata;

  always #2.5 clk = ~clk;

  wide_pair_seq #(.AW(AW), .DW(DW), .NBANK(NBANK)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .dbg_req(dbg_req), .dbg_write(dbg_write), .dbg_banked(dbg_banked),
    .dbg_bank(dbg_bank), .dbg_wide(dbg_wide), .dbg_wdata(dbg_wdata),
    .base_addr(base_addr),
    .dbg_ready(dbg_ready), .dbg_rdata(dbg_rdata), .dbg_err(dbg_err),
    .bus_req(bus_req), .bus_write(bus_write), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Scoreboard queues
  logic [DW-1:0]   exp_rd_q[$];
  logic            exp_err_q[$];
  string           exp_tag_q[$];
  logic            eb_wr_q[$];
  logic            eb_wide_q[$];
  logic [AW-1:0]   eb_addr_q[$];
  logic [2*DW-1:0] eb_wdata_q[$];
  string           eb_tag_q[$];

  // Bus responder configuration
  int              bus_lat = 2;
  logic            cfg_err = 1'b0;
  logic [2*DW-1:0] cfg_rdata = '0;
  int              bcnt = 0;
  logic            prev_req = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Bus slave model
  always @(negedge clk) begin
    if (bus_done) begin
      bus_done  = 1'b0;
      bus_err   = 1'b0;
      bus_rdata = '0;
      bcnt      = 0;
    end else if (rst_n && bus_req) begin
      bcnt++;
      if (bcnt >= bus_lat) begin
        bus_done  = 1'b1;
        bus_err   = cfg_err;
        bus_rdata = cfg_rdata;
      end
    end else begin
      bcnt = 0;
    end
  end

  // Bus monitor: compare each new bus request with the expected one
  always @(negedge clk) begin
    if (rst_n && bus_req && !prev_req) begin
      if (eb_wr_q.size() == 0) begin
        check(1'b0, "R11", "unexpected bus access addr", 64'(bus_addr), 64'h0);
      end else begin
        logic            ew, ewd;
        logic [AW-1:0]   ea;
        logic [2*DW-1:0] ed;
        string           et;
        ew = eb_wr_q.pop_front(); ewd = eb_wide_q.pop_front();
        ea = eb_addr_q.pop_front(); ed = eb_wdata_q.pop_front();
        et = eb_tag_q.pop_front();
        check(bus_write == ew && bus_wide == ewd, et, "bus {write,wide}",
              64'({bus_write, bus_wide}), 64'({ew, ewd}));
        check(bus_addr == ea, et, "bus addr", 64'(bus_addr), 64'(ea));
        if (ew) check(bus_wdata == ed, et, "bus wdata", bus_wdata, ed);
      end
    end
    prev_req = bus_req;
  end

  // Debug response monitor
  always @(negedge clk) begin
    if (rst_n && dbg_ready) begin
      if (exp_rd_q.size() == 0) begin
        check(1'b0, "R2", "unexpected ready", 64'd1, 64'd0);
      end else begin
        logic [DW-1:0] er;
        logic          ee;
        string         et;
        er = exp_rd_q.pop_front(); ee = exp_err_q.pop_front(); et = exp_tag_q.pop_front();
        check(dbg_rdata == er && dbg_err == ee, et, "response {err,rdata}",
              64'({dbg_err, dbg_rdata}), 64'({ee, er}));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R2 watchdog expired: got %0d cycles expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic exp_bus(input bit wr, input bit wide, input logic [AW-1:0] a,
                         input logic [2*DW-1:0] d, input string tag);
    eb_wr_q.push_back(wr); eb_wide_q.push_back(wide); eb_addr_q.push_back(a);
    eb_wdata_q.push_back(d); eb_tag_q.push_back(tag);
  endtask

  // Driver: pushes the expected response, runs one debug access
  task automatic access(input bit wr, input bit bk, input logic [1:0] idx, input bit wide,
                        input logic [DW-1:0] wd, input logic [DW-1:0] exp_rd,
                        input bit exp_err, input int exp_lat, input string tag);
    int lat = 0;
    exp_rd_q.push_back(exp_rd); exp_err_q.push_back(exp_err); exp_tag_q.push_back(tag);
    @(negedge clk);
    check(dbg_ready == 1'b0, "R2", "ready idle before request", 64'(dbg_ready), 64'd0);
    dbg_req = 1'b1; dbg_write = wr; dbg_banked = bk; dbg_bank = idx;
    dbg_wide = wide; dbg_wdata = wd;
    do begin
      @(negedge clk);
      lat++;
    end while (!dbg_ready && lat < 2000);
    dbg_req = 1'b0;
    if (!dbg_ready) check(1'b0, tag, "completion timeout", 64'(lat), 64'(exp_lat));
    else if (exp_lat > 0) check(lat == exp_lat, tag, "completion latency", 64'(lat), 64'(exp_lat));
  endtask

  initial begin
    rst_n = 1'b0;
    dbg_req = 1'b0; dbg_write = 1'b0; dbg_banked = 1'b0; dbg_bank = 2'd0;
    dbg_wide = 1'b0; dbg_wdata = '0; base_addr = BASE;
    bus_done = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    check(!dbg_ready && !dbg_err && !bus_req, "R1", "outputs in reset",
          64'({dbg_ready, dbg_err, bus_req}), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!dbg_ready && !dbg_err && !bus_req, "R1", "outputs after reset",
          64'({dbg_ready, dbg_err, bus_req}), 64'd0);

    // R3: narrow accesses
    cfg_rdata = 64'hAAAA_BBBB_1234_5678; cfg_err = 1'b0;
    exp_bus(1'b0, 1'b0, 32'h4A64, '0, "R3");
    access(1'b0, 1'b0, 2'd0, 1'b0, '0, 32'h1234_5678, 1'b0, 3, "R3");
    cfg_err = 1'b1;
    exp_bus(1'b1, 1'b0, 32'h4A64, 64'h0000_0000_CAFE_0001, "R3");
    access(1'b1, 1'b0, 2'd0, 1'b0, 32'hCAFE_0001, '0, 1'b1, 3, "R3");
    cfg_err = 1'b0;
    exp_bus(1'b1, 1'b0, 32'h4A6C, 64'h0000_0000_5A5A_0003, "R12");
    access(1'b1, 1'b1, 2'd3, 1'b0, 32'h5A5A_0003, '0, 1'b0, 3, "R12");

    // R4/R5: wide read pair on the data register
    cfg_rdata = 64'h89AB_CDEF_0123_4567;
    exp_bus(1'b0, 1'b1, 32'h4A60, '0, "R4");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, 32'h0123_4567, 1'b0, 3, "R4");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, 32'h89AB_CDEF, 1'b0, 1, "R5");

    // R6/R7: wide write pair
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h1111_2222, '0, 1'b0, 1, "R6");
    exp_bus(1'b1, 1'b1, 32'h4A60, 64'h3333_4444_1111_2222, "R7");
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h3333_4444, '0, 1'b0, 3, "R7");

    // R8: error on a wide read lands on the first read
    cfg_err = 1'b1; cfg_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
    exp_bus(1'b0, 1'b1, 32'h4A60, '0, "R8");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, '0, 1'b1, 3, "R8");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, '0, 1'b0, 1, "R8");

    // R9: error on a wide write lands on the second write
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_00B1, '0, 1'b0, 1, "R9");
    exp_bus(1'b1, 1'b1, 32'h4A60, 64'h0000_00B2_0000_00B1, "R9");
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_00B2, '0, 1'b1, 3, "R9");
    cfg_err = 1'b0;

    // R10: banked pairs
    cfg_rdata = 64'h5555_6666_7777_8888;
    exp_bus(1'b0, 1'b1, 32'h4A68, '0, "R10");
    access(1'b0, 1'b1, 2'd2, 1'b1, '0, 32'h7777_8888, 1'b0, 3, "R10");
    access(1'b0, 1'b1, 2'd3, 1'b1, '0, 32'h5555_6666, 1'b0, 1, "R10");
    access(1'b1, 1'b1, 2'd0, 1'b1, 32'hA0A0_A0A0, '0, 1'b0, 1, "R10");
    exp_bus(1'b1, 1'b1, 32'h4A60, 64'hB1B1_B1B1_A0A0_A0A0, "R12");
    access(1'b1, 1'b1, 2'd1, 1'b1, 32'hB1B1_B1B1, '0, 1'b0, 3, "R12");
    access(1'b0, 1'b1, 2'd1, 1'b1, '0, '0, 1'b1, 1, "R10");
    access(1'b1, 1'b1, 2'd3, 1'b1, 32'h0BAD_0BAD, '0, 1'b1, 1, "R10");

    // R11: direction change during a write pair drops the low half
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'hDEAD_0001, '0, 1'b0, 1, "R11");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, '0, 1'b1, 1, "R11");
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0C01, '0, 1'b0, 1, "R11");
    exp_bus(1'b1, 1'b1, 32'h4A60, 64'h0000_0C02_0000_0C01, "R11");
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0C02, '0, 1'b0, 3, "R11");

    // R11: wrong register during a read pair; the next read starts afresh
    cfg_rdata = 64'h1357_9BDF_2468_ACE0;
    exp_bus(1'b0, 1'b1, 32'h4A60, '0, "R11");
    access(1'b0, 1'b1, 2'd0, 1'b1, '0, 32'h2468_ACE0, 1'b0, 3, "R11");
    access(1'b0, 1'b1, 2'd2, 1'b1, '0, '0, 1'b1, 1, "R11");
    cfg_rdata = 64'hCCCC_0002_CCCC_0001;
    exp_bus(1'b0, 1'b1, 32'h4A60, '0, "R11");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, 32'hCCCC_0001, 1'b0, 3, "R11");
    access(1'b0, 1'b0, 2'd0, 1'b1, '0, 32'hCCCC_0002, 1'b0, 1, "R11");

    // R11: wrong bank member, and other register kind, during write pairs
    access(1'b1, 1'b1, 2'd2, 1'b1, 32'h0000_0E01, '0, 1'b0, 1, "R11");
    access(1'b1, 1'b1, 2'd1, 1'b1, 32'h0000_0E02, '0, 1'b1, 1, "R11");
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0F01, '0, 1'b0, 1, "R11");
    access(1'b1, 1'b1, 2'd1, 1'b1, 32'h0000_0F02, '0, 1'b1, 1, "R11");

    // R13: partner with the wide flag dropped still completes the pair
    access(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0D01, '0, 1'b0, 1, "R13");
    exp_bus(1'b1, 1'b1, 32'h4A60, 64'h0000_0D02_0000_0D01, "R13");
    access(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_0D02, '0, 1'b0, 3, "R13");

    repeat (6) @(negedge clk);
    check(exp_rd_q.size() == 0, "R2", "responses outstanding", 64'(exp_rd_q.size()), 64'd0);
    check(eb_wr_q.size() == 0, "R7", "bus accesses missing", 64'(eb_wr_q.size()), 64'd0);
    summary();
    $finish;
  end

endmodule